// File: doc/BRIEF.md
# Presettable Up Counter with Auto-Reload

This block is an 8-bit binary up counter whose every state change happens on the rising clock edge, apart from an asynchronous master reset. It loads a parallel preset word on request and advances by one when both of its active-low count enables are low. An active-low terminal-count flag reports that counting is enabled while the count sits at all ones. Because that flag is taken from the registered count and the enable pins, and not from a ripple decode, it serves as the enable of a further stage. Counters wider than 8 bits are built by chaining stages this way.

A mode input feeds the terminal count back into the counter. With the mode low, the counter wraps from all ones to zero and keeps going. With the mode high, the clock edge that would wrap the counter loads the preset instead. The block is then a programmable divider with a ratio of 256 minus the preset, and it needs no outside logic. An integrator who leaves the mode unused must tie it low. That gives the free-running behaviour.

Top module: `upcnt_reload`

## Requirements
- R1: When `load` is low and both `cen_a_n` and `cen_b_n` are low, a rising clock edge sets `q` to its previous value plus one (modulo 256), unless R4 applies.
- R2: `tc_n` is 0 exactly when both count enables are low and `q` equals 8'hFF. Otherwise it is 1.
- R3: With `auto_reload` low and counting enabled, the edge that finds `q` at 8'hFF sets `q` to 8'h00.
- R4: With `auto_reload` high and `tc_n` low, the next edge (with `load` low) sets `q` to `preset`. With preset P, `tc_n` therefore pulses low once every 256 − P clocks.
- R5: When `load` is high, the next edge sets `q` to `preset`. This holds whatever the enables, the mode or the current count.
- R6: When `load` is low and either count enable is high, `q` keeps its value across the edge.
- R7: While `mrst` is high, `q` is 8'h00 at once, without a clock edge, and stays there. `tc_n` is then 1.
- R8: When the `tc_n` of a lower stage drives `cen_a_n` of an upper stage, the upper stage advances exactly once for each rollover of the lower stage, so the pair counts as one 16-bit counter.
- R9: With `auto_reload` high, `preset` equal to 8'hFF and counting enabled, `q` stays at 8'hFF and `tc_n` stays low on every cycle (divide by one).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| mrst | input | 1 | Asynchronous master reset, active high |
| load | input | 1 | Synchronous parallel load of `preset`, active high |
| cen_a_n | input | 1 | Count enable A, active low |
| cen_b_n | input | 1 | Count enable B, active low |
| auto_reload | input | 1 | Terminal-count feedback mode; high reloads the preset at terminal count |
| preset | input | W (8) | Parallel preset word |
| q | output | W (8) | Registered count |
| tc_n | output | 1 | Terminal count, active low |

## Verification
The hardest condition to reach is the upper stage of a cascade reaching its own terminal count. It only moves on a lower-stage rollover, so free running would take 65,536 clocks to get there. The bench first uses a parallel load to place the upper stage at 8'hFE. The lower stage then rolls over twice, which shows the upper stage advancing one step per rollover and raising its own `tc_n` only while the lower stage's flag is also active. The divide-by-one corner is reached by loading all ones with the mode high and holding the enables low.

// File: rtl/upcnt_reload.sv
module upcnt_reload #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         mrst,
  input  logic         load,
  input  logic         cen_a_n,
  input  logic         cen_b_n,
  input  logic         auto_reload,
  input  logic [W-1:0] preset,
  output logic [W-1:0] q,
  output logic         tc_n
);

  logic count_en;
  logic at_top;

  assign count_en = ~cen_a_n & ~cen_b_n;
  assign at_top   = &q;
  assign tc_n     = ~(count_en & at_top);

  always_ff @(posedge clk or posedge mrst) begin
    if (mrst)
      q <= '0;
    else if (load)
      q <= preset;
    else if (count_en)
      q <= (auto_reload & at_top) ? preset : q + 1'b1;
  end

endmodule

module upcnt_reload_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         mrst,
  input logic         load,
  input logic         cen_a_n,
  input logic         cen_b_n,
  input logic         auto_reload,
  input logic [W-1:0] preset,
  input logic [W-1:0] q,
  input logic         tc_n
);

  p_inc_r1: assert property (@(posedge clk) disable iff (mrst)
    (!load && !cen_a_n && !cen_b_n && q != {W{1'b1}}) |=> q == $past(q) + 1'b1);

  p_tc_at_top_r2: assert property (@(posedge clk) disable iff (mrst)
    !tc_n |-> (q == {W{1'b1}}));

  p_wrap_r3: assert property (@(posedge clk) disable iff (mrst)
    (!load && !auto_reload && !tc_n) |=> q == '0);

  p_reload_r4: assert property (@(posedge clk) disable iff (mrst)
    (!load && auto_reload && !tc_n) |=> q == $past(preset));

  p_load_r5: assert property (@(posedge clk) disable iff (mrst)
    load |=> q == $past(preset));

  p_hold_r6: assert property (@(posedge clk) disable iff (mrst)
    (!load && (cen_a_n || cen_b_n)) |=> $stable(q));

endmodule

bind upcnt_reload upcnt_reload_chk #(.W(W)) u_chk (
  .clk(clk), .mrst(mrst), .load(load), .cen_a_n(cen_a_n), .cen_b_n(cen_b_n),
  .auto_reload(auto_reload), .preset(preset), .q(q), .tc_n(tc_n)
);

// File: tb/upcnt_reload_test.sv
module upcnt_reload_test;
  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       mrst = 1'b1;
  logic       load = 1'b0, cen_a_n = 1'b0, cen_b_n = 1'b0, auto_reload = 1'b0;
  logic [7:0] preset = 8'h00;
  logic       hi_load = 1'b0, hi_cen_n = 1'b0;
  logic [7:0] hi_preset = 8'h00;
  logic [7:0] q_lo, q_hi;
  logic       tc_lo_n, tc_hi_n;

  int n_checks = 0, n_fail = 0;
  int ref_lo = 0, ref_hi = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  upcnt_reload #(.W(8)) uut (
    .clk(clk), .mrst(mrst), .load(load), .cen_a_n(cen_a_n), .cen_b_n(cen_b_n),
    .auto_reload(auto_reload), .preset(preset), .q(q_lo), .tc_n(tc_lo_n));

  upcnt_reload #(.W(8)) uut_hi (
    .clk(clk), .mrst(mrst), .load(hi_load), .cen_a_n(tc_lo_n), .cen_b_n(hi_cen_n),
    .auto_reload(1'b0), .preset(hi_preset), .q(q_hi), .tc_n(tc_hi_n));

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit lo_en();
    return !cen_a_n && !cen_b_n;
  endfunction

  function automatic bit lo_tc();
    return lo_en() && ref_lo == 255;
  endfunction

  task automatic step(input string tag);
    bit tc_pre, hi_en;
    @(posedge clk);
    tc_pre = lo_tc();
    hi_en  = tc_pre && !hi_cen_n;
    if (load) ref_lo = preset;
    else if (lo_en()) ref_lo = (auto_reload && ref_lo == 255) ? preset : (ref_lo + 1) % 256;
    if (hi_load) ref_hi = hi_preset;
    else if (hi_en) ref_hi = (ref_hi + 1) % 256;
    @(negedge clk);
    chk({tag, " q"}, q_lo, ref_lo);
    chk("R2 tc_n", tc_lo_n, lo_tc() ? 0 : 1);
    chk("R8 upper q", q_hi, ref_hi);
    chk("R8 upper tc_n", tc_hi_n, (lo_tc() && !hi_cen_n && ref_hi == 255) ? 0 : 1);
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int last;
    #(PERIOD * 2 + 1);
    chk("R7 reset q", q_lo, 0);
    chk("R7 reset tc_n", tc_lo_n, 1);
    @(negedge clk); mrst = 1'b0;

    // R1 R3: free run through two wraps
    for (int i = 0; i < 520; i++) step("R1/R3 count");

    // R6: hold with either enable high
    cen_b_n = 1'b1;
    for (int i = 0; i < 5; i++) step("R6 hold b");
    cen_b_n = 1'b0; cen_a_n = 1'b1;
    for (int i = 0; i < 5; i++) step("R6 hold a");

    // R5: load while disabled, then load over reload at terminal count
    load = 1'b1; preset = 8'hFD; step("R5 load disabled");
    load = 1'b0; cen_a_n = 1'b0;
    step("R1 after load"); step("R1 after load");
    auto_reload = 1'b1; load = 1'b1; preset = 8'h10; step("R5 load over reload");
    load = 1'b0; auto_reload = 1'b0;

    // R8: upper stage placed near its top, lower rolled over twice
    hi_load = 1'b1; hi_preset = 8'hFE; load = 1'b1; preset = 8'hF0; step("R8 preload");
    hi_load = 1'b0; load = 1'b0;
    for (int i = 0; i < 600; i++) step("R8 cascade");
    hi_cen_n = 1'b1;
    for (int i = 0; i < 260; i++) step("R8 upper held");
    hi_cen_n = 1'b0;

    // R4: divider with preset 250, ratio 6
    auto_reload = 1'b1; preset = 8'd250;
    load = 1'b1; step("R4 start"); load = 1'b0;
    last = -1;
    for (int i = 0; i < 40; i++) begin
      step("R4 reload");
      if (tc_lo_n == 1'b0) begin
        if (last >= 0) chk("R4 ratio", i - last, 6);
        last = i;
      end
    end

    // R9: divide by one
    preset = 8'hFF;
    for (int i = 0; i < 12; i++) begin
      step("R9 div1");
      chk("R9 tc low", tc_lo_n, 0);
    end

    // R7: asynchronous reset between edges
    auto_reload = 1'b0; preset = 8'h00;
    step("R1 pre-reset");
    #(PERIOD / 4);
    mrst = 1'b1;
    #1;
    chk("R7 async q", q_lo, 0);
    chk("R7 async tc_n", tc_lo_n, 1);
    chk("R7 async upper q", q_hi, 0);
    ref_lo = 0; ref_hi = 0;
    @(negedge clk);
    chk("R7 held q", q_lo, 0);
    mrst = 1'b0;
    for (int i = 0; i < 4; i++) step("R1 after reset");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule